// File: doc/BRIEF.md
# Short-Vector Load Distribution Unit

This unit steers short-vector loads from three on-chip memory banks into the register files of two compute blocks, X and Y. Each cycle it accepts up to two load requests, one on each port. A request names a bank, a word address, a word count from one to four and a distribution mode. The selected bank returns one 128-bit line of four 32-bit words. The unit extracts the requested consecutive words and produces, for each port, per-lane write enables and data for block X and for block Y. It also produces a destination base register index that both blocks share. Lane j of a port writes register `base + j`.

There are four distribution modes. In direct mode all words go to one block. In split mode the first half of the words goes to X and the second half goes to Y. In broadcast mode every word goes to both blocks. Malformed requests raise a per-port error flag and write nothing.

A two-state arbiter resolves bank conflicts between the ports:
- `ARB_RUN` is the normal state, with `ld_ready` high. When both ports present a request to the same bank, port 0 issues. Port 1's request is captured and the arbiter takes the transition RUN→REPLAY.
- `ARB_REPLAY` holds `ld_ready` low, issues the captured port 1 request, ignores all inputs and always takes the transition REPLAY→RUN.
- With no conflict the arbiter stays in RUN.

The memory banks are behavioural arrays. At reset they load a fixed pattern.

Top module: `vld_top`

## Requirements
- R1: After reset `ld_ready` is 1, and all write enables and error flags are 0.
- R2: A request accepted at a clock edge (valid with `ld_ready` high) drives its write enables, data, base index and error flag during the following cycle only.
- R3: Mode 0 (direct X) writes the count words starting at word address `addr` to X lanes 0..count-1. Mode 1 (direct Y) does the same on Y. The other block gets no writes.
- R4: Mode 2 (split) with count n writes words 0..n/2-1 to X lanes 0..n/2-1 and words n/2..n-1 to Y lanes 0..n/2-1. Both blocks use the same base index.
- R5: Mode 3 (broadcast) writes all count words to lanes 0..count-1 of both X and Y.
- R6: A split request with an odd count (1 or 3) raises the port's error flag and produces no write enables.
- R7: A request with (addr mod 4) + count > 4, which crosses a 128-bit line, raises the error flag and writes nothing.
- R8: A request naming bank 3, where only banks 0 to 2 exist, raises the error flag and writes nothing.
- R9: When both ports are valid with equal bank fields while `ld_ready` is high, port 0 issues at once. Port 1 issues one cycle later. During that later cycle `ld_ready` is 0 and all inputs are ignored.
- R10: Two valid requests to different banks issue in the same cycle.
- R11: Bank b holds, at word address a, the value 0xB0000000 | (b << 16) | a. Count is encoded as `ld_cnt` = count-1. Port p uses the bit slices p*W of each packed input and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 2 | Request valid, one bit per port |
| ld_bank | input | 4 | Bank index, 2 bits per port |
| ld_addr | input | 2*(clog2(LINES)+2) | Word address per port |
| ld_cnt | input | 4 | Word count minus one, 2 bits per port |
| ld_mode | input | 4 | Distribution mode per port (0 direct X, 1 direct Y, 2 split, 3 broadcast) |
| ld_dst | input | 10 | Destination base register index, 5 bits per port |
| ld_ready | output | 1 | High when new requests are accepted |
| x_we | output | 8 | Block X lane write enables, 4 per port |
| x_data | output | 256 | Block X lane data, 128 bits per port |
| y_we | output | 8 | Block Y lane write enables, 4 per port |
| y_data | output | 256 | Block Y lane data, 128 bits per port |
| wr_base | output | 10 | Base register index per port, shared by X and Y |
| ld_err | output | 2 | Rejected-request flag per port |

## Verification
Every result appears exactly one cycle after the edge that accepts or replays its request. `ld_ready` is a function of the current arbiter state, so it is due immediately after the edge that follows a conflict. The bench drives inputs at the falling edge and checks `ld_ready` just after that. Its reference model then predicts what the next rising edge issues. The bench compares all write enables, enabled-lane data, base indices and error flags at the following falling edge. It never looks for a result in any other cycle.

// File: rtl/vld_pkg.sv
package vld_pkg;
    localparam int NPORT  = 2;
    localparam int LANES  = 4;
    localparam int WORD_W = 32;
    localparam int LINE_B = LANES * WORD_W;
    localparam int REG_W  = 5;
    localparam int BANK_W = 2;
    localparam int NBANK  = 3;

    typedef enum logic [1:0] {
        DM_DIRECT_X = 2'd0,
        DM_DIRECT_Y = 2'd1,
        DM_SPLIT    = 2'd2,
        DM_BCAST    = 2'd3
    } dist_mode_t;

    typedef enum logic {
        ARB_RUN    = 1'b0,
        ARB_REPLAY = 1'b1
    } arb_state_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [1:0]        off;
        logic [1:0]        cm1;
        dist_mode_t        mode;
        logic [REG_W-1:0]  dst;
    } ld_req_t;
endpackage

// File: rtl/vld_bank.sv
module vld_bank
    import vld_pkg::*;
#(
    parameter int BANK_ID = 0,
    parameter int LINES   = 16,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [LINE_W-1:0] rd_line,
    output logic [LINE_B-1:0] rd_data
);
    logic [LINE_B-1:0] mem [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) begin
                for (int w = 0; w < LANES; w++) begin
                    mem[l][w*WORD_W +: WORD_W] <= 32'hB000_0000
                        | (32'(BANK_ID) << 16) | 32'(l * LANES + w);
                end
            end
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_line];
        end
    end
endmodule

// File: rtl/vld_arbiter.sv
module vld_arbiter
    import vld_pkg::*;
#(
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORT-1:0]  valid,
    input  ld_req_t           req_in   [NPORT],
    input  logic [LINE_W-1:0] line_in  [NPORT],
    output logic              ready,
    output logic [NPORT-1:0]  issue,
    output ld_req_t           req_out  [NPORT],
    output logic [LINE_W-1:0] line_out [NPORT]
);
    arb_state_t        state, nxt;
    ld_req_t           hold_req;
    logic [LINE_W-1:0] hold_line;
    logic              conflict;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARB_RUN;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_req  <= '0;
            hold_line <= '0;
        end else if (conflict) begin
            hold_req  <= req_in[1];
            hold_line <= line_in[1];
        end
    end

    always_comb begin
        conflict = 1'b0;
        ready    = 1'b1;
        issue    = '0;
        nxt      = state;
        req_out  = req_in;
        line_out = line_in;
        unique case (state)
            ARB_RUN: begin
                conflict = valid[0] && valid[1] && (req_in[0].bank == req_in[1].bank);
                issue[0] = valid[0];
                issue[1] = valid[1] && !conflict;
                nxt      = conflict ? ARB_REPLAY : ARB_RUN;
            end
            ARB_REPLAY: begin
                ready       = 1'b0;
                issue       = 2'b10;
                req_out[1]  = hold_req;
                line_out[1] = hold_line;
                nxt         = ARB_RUN;
            end
        endcase
    end

    AST_REPLAY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ARB_REPLAY |=> state == ARB_RUN); // R9
    AST_STALL_AFTER_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && valid == 2'b11 && req_in[0].bank == req_in[1].bank)
        |=> (!ready && issue == 2'b10)); // R9
    AST_DISJOINT_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        issue == 2'b11 |-> req_out[0].bank != req_out[1].bank); // R10
endmodule

// File: rtl/vld_steer.sv
module vld_steer
    import vld_pkg::*;
(
    input  logic              v,
    input  ld_req_t           req,
    input  logic [LINE_B-1:0] line,
    output logic [LANES-1:0]  x_we,
    output logic [LANES-1:0]  y_we,
    output logic [LINE_B-1:0] x_data,
    output logic [LINE_B-1:0] y_data,
    output logic              err
);
    logic [2:0]        n, half;
    logic [3:0]        span;
    logic [LANES-1:0]  mask_n, mask_h;
    logic [WORD_W-1:0] sh [LANES];
    logic              ok;

    always_comb begin
        n    = {1'b0, req.cm1} + 3'd1;
        half = n >> 1;
        span = {2'b00, req.off} + {1'b0, n};
        err  = v && ((span > 4'd4) || (req.bank >= BANK_W'(NBANK))
                     || (req.mode == DM_SPLIT && !req.cm1[0]));
        ok   = v && !err;
        for (int j = 0; j < LANES; j++) begin
            mask_n[j] = (3'(j) < n);
            mask_h[j] = (3'(j) < half);
            sh[j]     = '0;
            if (int'(req.off) + j < LANES)
                sh[j] = line[(int'(req.off) + j)*WORD_W +: WORD_W];
        end
        x_we   = '0;
        y_we   = '0;
        x_data = '0;
        y_data = '0;
        unique case (req.mode)
            DM_DIRECT_X: begin
                x_we = mask_n;
                for (int j = 0; j < LANES; j++) x_data[j*WORD_W +: WORD_W] = sh[j];
            end
            DM_DIRECT_Y: begin
                y_we = mask_n;
                for (int j = 0; j < LANES; j++) y_data[j*WORD_W +: WORD_W] = sh[j];
            end
            DM_SPLIT: begin
                x_we = mask_h;
                y_we = mask_h;
                for (int j = 0; j < LANES; j++) begin
                    x_data[j*WORD_W +: WORD_W] = sh[j];
                    if (j + int'(half) < LANES)
                        y_data[j*WORD_W +: WORD_W] = sh[j + int'(half)];
                end
            end
            DM_BCAST: begin
                x_we = mask_n;
                y_we = mask_n;
                for (int j = 0; j < LANES; j++) begin
                    x_data[j*WORD_W +: WORD_W] = sh[j];
                    y_data[j*WORD_W +: WORD_W] = sh[j];
                end
            end
        endcase
        if (!ok) begin
            x_we = '0;
            y_we = '0;
        end
    end
endmodule

// File: rtl/vld_top.sv
module vld_top
    import vld_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [1:0]                         ld_valid,
    input  logic [3:0]                         ld_bank,
    input  logic [2*($clog2(LINES)+2)-1:0]     ld_addr,
    input  logic [3:0]                         ld_cnt,
    input  logic [3:0]                         ld_mode,
    input  logic [9:0]                         ld_dst,
    output logic                               ld_ready,
    output logic [7:0]                         x_we,
    output logic [255:0]                       x_data,
    output logic [7:0]                         y_we,
    output logic [255:0]                       y_data,
    output logic [9:0]                         wr_base,
    output logic [1:0]                         ld_err
);
    localparam int LINE_W = $clog2(LINES);
    localparam int ADDR_W = LINE_W + 2;

    ld_req_t           req_in   [NPORT];
    logic [LINE_W-1:0] line_in  [NPORT];
    ld_req_t           req_iss  [NPORT];
    logic [LINE_W-1:0] line_iss [NPORT];
    logic [NPORT-1:0]  issue;
    logic [LINE_B-1:0] bank_q   [NBANK];
    logic [NPORT-1:0]  s1_v;
    ld_req_t           s1_req   [NPORT];
    logic [LINE_B-1:0] s1_line  [NPORT];

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            req_in[p].bank = ld_bank[p*BANK_W +: BANK_W];
            req_in[p].off  = ld_addr[p*ADDR_W +: 2];
            req_in[p].cm1  = ld_cnt[p*2 +: 2];
            req_in[p].mode = dist_mode_t'(ld_mode[p*2 +: 2]);
            req_in[p].dst  = ld_dst[p*REG_W +: REG_W];
            line_in[p]     = ld_addr[p*ADDR_W + 2 +: LINE_W];
        end
    end

    vld_arbiter #(.LINE_W(LINE_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (ld_valid),
        .req_in   (req_in),
        .line_in  (line_in),
        .ready    (ld_ready),
        .issue    (issue),
        .req_out  (req_iss),
        .line_out (line_iss)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic              hit0, hit1;
        logic [LINE_W-1:0] sel_line;
        assign hit0     = issue[0] && (req_iss[0].bank == BANK_W'(b));
        assign hit1     = issue[1] && (req_iss[1].bank == BANK_W'(b));
        assign sel_line = hit0 ? line_iss[0] : line_iss[1];
        vld_bank #(.BANK_ID(b), .LINES(LINES)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (hit0 || hit1),
            .rd_line (sel_line),
            .rd_data (bank_q[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v <= '0;
            for (int p = 0; p < NPORT; p++) s1_req[p] <= '0;
        end else begin
            s1_v <= issue;
            for (int p = 0; p < NPORT; p++) s1_req[p] <= req_iss[p];
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            s1_line[p] = '0;
            for (int b = 0; b < NBANK; b++)
                if (s1_req[p].bank == BANK_W'(b)) s1_line[p] = bank_q[b];
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        vld_steer u_steer (
            .v      (s1_v[p]),
            .req    (s1_req[p]),
            .line   (s1_line[p]),
            .x_we   (x_we[p*LANES +: LANES]),
            .y_we   (y_we[p*LANES +: LANES]),
            .x_data (x_data[p*LINE_B +: LINE_B]),
            .y_data (y_data[p*LINE_B +: LINE_B]),
            .err    (ld_err[p])
        );
        assign wr_base[p*REG_W +: REG_W] = s1_req[p].dst;

        AST_ERR_WRITES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
            ld_err[p] |-> (x_we[p*LANES +: LANES] == '0 && y_we[p*LANES +: LANES] == '0)); // R6
        AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
            (!issue[p]) |=> (x_we[p*LANES +: LANES] == '0 && y_we[p*LANES +: LANES] == '0
                             && !ld_err[p])); // R2
    end
endmodule

// File: tb/vld_top_bench.sv
module vld_top_bench;
    localparam int LINES  = 16;
    localparam int ADDR_W = $clog2(LINES) + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        ld_valid = '0;
    logic [3:0]        ld_bank = '0;
    logic [2*ADDR_W-1:0] ld_addr = '0;
    logic [3:0]        ld_cnt = '0;
    logic [3:0]        ld_mode = '0;
    logic [9:0]        ld_dst = '0;
    logic              ld_ready;
    logic [7:0]        x_we, y_we;
    logic [255:0]      x_data, y_data;
    logic [9:0]        wr_base;
    logic [1:0]        ld_err;

    int errors = 0;
    int checks = 0;

    // reference model state
    bit          m_replay = 0;
    int          h_b, h_a, h_c, h_m, h_d;
    logic [7:0]  e_xwe, e_ywe;
    logic [255:0] e_xd, e_yd;
    logic [9:0]  e_base;
    logic [1:0]  e_err;

    always #5 clk = ~clk;

    vld_top #(.LINES(LINES)) u_vld_top (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_bank(ld_bank),
        .ld_addr(ld_addr), .ld_cnt(ld_cnt), .ld_mode(ld_mode), .ld_dst(ld_dst),
        .ld_ready(ld_ready), .x_we(x_we), .x_data(x_data), .y_we(y_we),
        .y_data(y_data), .wr_base(wr_base), .ld_err(ld_err)
    );

    function automatic logic [31:0] memword(int b, int a);
        return 32'hB000_0000 | (32'(b) << 16) | 32'(a);
    endfunction

    task automatic check(string tag, string what, logic [255:0] got, logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // predict the outputs of port p for one issued request
    task automatic model(int p, bit v, int b, int a, int c, int m, int d);
        int off, n, h;
        bit bad;
        off = a % 4; n = c + 1; h = n / 2;
        bad = (b > 2) || (off + n > 4) || (m == 2 && (n % 2) == 1);
        e_base[p*5 +: 5] = 5'(d);
        if (!v) return;
        if (bad) begin e_err[p] = 1'b1; return; end
        for (int j = 0; j < n; j++) begin
            if (m == 0 || m == 3) begin
                e_xwe[p*4+j] = 1'b1; e_xd[p*128 + j*32 +: 32] = memword(b, a + j);
            end
            if (m == 1 || m == 3) begin
                e_ywe[p*4+j] = 1'b1; e_yd[p*128 + j*32 +: 32] = memword(b, a + j);
            end
        end
        if (m == 2) begin
            for (int j = 0; j < h; j++) begin
                e_xwe[p*4+j] = 1'b1; e_xd[p*128 + j*32 +: 32] = memword(b, a + j);
                e_ywe[p*4+j] = 1'b1; e_yd[p*128 + j*32 +: 32] = memword(b, a + h + j);
            end
        end
    endtask

    task automatic compare_out(string tag);
        check(tag, "x_we", 256'(x_we), 256'(e_xwe));
        check(tag, "y_we", 256'(y_we), 256'(e_ywe));
        check(tag, "ld_err", 256'(ld_err), 256'(e_err));
        for (int p = 0; p < 2; p++) begin
            if ((e_xwe[p*4 +: 4] | e_ywe[p*4 +: 4]) != 0)
                check(tag, "wr_base", 256'(wr_base[p*5 +: 5]), 256'(e_base[p*5 +: 5]));
            for (int j = 0; j < 4; j++) begin
                if (e_xwe[p*4+j])
                    check(tag, "x_data", 256'(x_data[p*128 + j*32 +: 32]), 256'(e_xd[p*128 + j*32 +: 32]));
                if (e_ywe[p*4+j])
                    check(tag, "y_data", 256'(y_data[p*128 + j*32 +: 32]), 256'(e_yd[p*128 + j*32 +: 32]));
            end
        end
    endtask

    // called at a falling edge: drive, predict, advance one cycle, compare
    task automatic cyc(string tag,
                       bit v0, int b0, int a0, int c0, int m0, int d0,
                       bit v1, int b1, int a1, int c1, int m1, int d1);
        bit conflict;
        ld_valid = {1'(v1), 1'(v0)};
        ld_bank  = {2'(b1), 2'(b0)};
        ld_addr  = {ADDR_W'(a1), ADDR_W'(a0)};
        ld_cnt   = {2'(c1), 2'(c0)};
        ld_mode  = {2'(m1), 2'(m0)};
        ld_dst   = {5'(d1), 5'(d0)};
        #1;
        check(m_replay ? "R9" : tag, "ld_ready", 256'(ld_ready), 256'(!m_replay));
        e_xwe = '0; e_ywe = '0; e_xd = '0; e_yd = '0; e_err = '0; e_base = '0;
        if (m_replay) begin
            model(1, 1'b1, h_b, h_a, h_c, h_m, h_d);
            m_replay = 0;
        end else begin
            conflict = v0 && v1 && (b0 % 4) == (b1 % 4);
            model(0, v0, b0 % 4, a0, c0, m0, d0);
            model(1, v1 && !conflict, b1 % 4, a1, c1, m1, d1);
            if (conflict) begin
                m_replay = 1;
                h_b = b1 % 4; h_a = a1; h_c = c1; h_m = m1; h_d = d1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare_out(tag);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "ld_ready", 256'(ld_ready), 256'(1));
        check("R1", "x_we", 256'(x_we), 256'(0));
        check("R1", "y_we", 256'(y_we), 256'(0));
        check("R1", "ld_err", 256'(ld_err), 256'(0));
        // R3 direct X, full line, and direct Y on another bank (R10, R11)
        cyc("R3", 1, 0, 4, 3, 0, 3,   1, 1, 9, 1, 1, 20);
        idle("R2");
        // R4 split four words / two words
        cyc("R4", 1, 2, 8, 3, 2, 7,   1, 0, 62, 1, 2, 30);
        // R5 broadcast three words at offset 1
        cyc("R5", 1, 1, 17, 2, 3, 11, 0, 0, 0, 0, 0, 0);
        // R6 odd split counts
        cyc("R6", 1, 0, 0, 0, 2, 1,   1, 2, 4, 2, 2, 2);
        // R7 line crossing
        cyc("R7", 1, 1, 3, 1, 0, 1,   1, 2, 6, 3, 3, 2);
        // R8 bank 3
        cyc("R8", 1, 3, 0, 0, 0, 1,   0, 0, 0, 0, 0, 0);
        // R9 conflict, then replay cycle with inputs that must be ignored
        cyc("R9", 1, 1, 20, 3, 0, 4,  1, 1, 33, 2, 3, 9);
        cyc("R9", 1, 0, 0, 3, 3, 31,  1, 2, 0, 3, 3, 31);
        idle("R2");
        // R9 conflict on bank 3 still serialises, both reject (R8)
        cyc("R9", 1, 3, 0, 0, 0, 0,   1, 3, 0, 0, 1, 0);
        idle("R9");
        // R10 all banks busy across ports back to back
        cyc("R10", 1, 2, 60, 3, 1, 12, 1, 0, 1, 0, 3, 13);
        cyc("R10", 1, 0, 52, 3, 2, 14, 1, 1, 44, 3, 1, 15);
        lf = 16'hACE1;
        for (int i = 0; i < 120; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc("R11", lf[0], lf[2:1] % 3 + (lf[14:11] == 0 ? 1 : 0), int'(lf[8:3]) % 64,
                lf[10:9], lf[12:11], int'(lf[15:11]),
                lf[1], lf[4:3] % 3, int'(lf[14:9]) % 64, lf[6:5], lf[8:7], int'(lf[7:3]));
        end
        idle("R2");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule